// File: doc/BRIEF.md
# Texture Texel Address Generator

This block turns one integer texel coordinate pair into the memory location of that texel. Each axis first goes through its own boundary rule: repeat, reflect or pin to the edge. The result is limited to the width or height of the selected mipmap level, and that level's storage is found after all the lower-numbered levels. The block then applies either a row-by-row layout or a tiled layout. It reports the address of the 64-bit word that holds the texel and the bit position of the texel inside that word.

A request carries a texture base address, a 20-bit control word, signed U and V, and a level index. Requests enter under a valid/ready handshake. Results leave one cycle later under a second valid/ready handshake, together with the texel depth code. A result that the consumer has not taken holds its value until it is taken.

Top module: `tex_addr_gen`

## Requirements
- R1: An accepted request (`in_valid` and `in_ready` high at a clock edge) is presented on the outputs from the next edge, with `out_valid` high. `in_ready` is high whenever no result is held, or the held result is being taken in the same cycle.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_bitoff` and `out_depth` keep their values.
- R3: Boundary code 0 (and the reserved code 3) wraps the coordinate. The index is the coordinate modulo the level size, and negative coordinates wrap from the top.
- R4: Boundary code 1 mirrors the coordinate. With p = floor(c / size) and m = c mod size, the index is m when p is even and size-1-m when p is odd.
- R5: Boundary code 2 clamps the coordinate. Negative values give 0, values of at least size give size-1, and all other values pass unchanged.
- R6: The level used is the smallest of `in_lod`, the map-count field and 8. Level n is max(1, 2^(X-n)) texels wide and max(1, 2^(Y-n)) texels tall.
- R7: The storage for level n starts at the base address plus the sum of the sizes of levels 0 to n-1. In linear mode a level occupies pitch × height bytes. In tiled mode it occupies 32 bytes per tile, with whole tiles across and down.
- R8: The three low bits of the base address are treated as zero. In linear mode the row pitch is the width × bpp / 8 bytes, rounded up to a multiple of 8. The word address is level start + y × pitch + 8 × floor(x × bpp / 64). `out_bitoff` is (x × bpp) mod 64, with texels packed from bit 0 upward.
- R9: The depth code sets bits per texel as follows: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 to 6 give 16, and 7 gives 32. The code is passed through unchanged on `out_depth`.
- R10: In tiled mode the tile size (width × height) depends on bpp: 1 → 16×16, 2 → 8×16, 4 → 8×8, 8 → 4×8, 16 → 4×4, 32 → 2×4. Each tile holds 32 bytes, and tiles are stored row by row across the level.
- R11: Inside a tile, texels form 2×2 groups stored in row-major group order. Within a group the texel order is (0,0), (1,0), (0,1), (1,1). The texel number t gives bit t × bpp of the tile, from which the word (8-byte step) and `out_bitoff` follow.
- R12: While reset is applied, `out_valid` is low on the next edge, and after reset `in_ready` is high.
- R13: The control word has the following fields: U boundary [1:0], V boundary [3:2], log2 full width X [7:4], log2 full height Y [11:8], map count minus one [15:12], depth code [18:16], and tiled enable [19]. X, Y or map-count values above 8 act as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at this edge when valid |
| in_base | input | 32 | Texture base byte address |
| in_ctrl | input | 20 | Control word (R13) |
| in_u | input | 16 | Signed U texel coordinate |
| in_v | input | 16 | Signed V texel coordinate |
| in_lod | input | 4 | Requested mipmap level |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Byte address of the 64-bit word holding the texel |
| out_bitoff | output | 6 | Bit position of the texel within that word |
| out_depth | output | 3 | Texel depth code of the request |

## Verification
Any error in the folded index, the level offset or the tile arithmetic appears in the very result that comes out one cycle after the request. The scoreboard therefore catches it on the first request that reaches the faulty case, and that result is the request's own. Directed requests target each boundary code with negative and out-of-range coordinates, level clamping, every depth in both layouts and positions inside the subtiles. A long pseudo-random run spreads the remaining corner combinations. Handshake faults show up as lost, repeated or changed results while the consumer stalls.

// File: rtl/tex_addr_pkg.sv
// Shared types and small arithmetic helpers for the texel address generator.
// Assumes all sizes are powers of two and stored as 5-bit log2 values.
package tex_addr_pkg;

    localparam int MAX_LOG   = 8;           // largest log2 map dimension
    localparam int MAX_LVLS  = MAX_LOG + 1; // number of mipmap levels possible
    localparam int CTRL_W    = 20;

    typedef logic [4:0] lg_t;

    typedef enum logic [1:0] {
        BND_REPEAT  = 2'd0,
        BND_REFLECT = 2'd1,
        BND_PIN     = 2'd2,
        BND_SPARE   = 2'd3
    } bnd_mode_t;

    // Bit positions inside the control word.
    localparam int F_UMODE = 0;
    localparam int F_VMODE = 2;
    localparam int F_XLOG  = 4;
    localparam int F_YLOG  = 8;
    localparam int F_LVLS  = 12;
    localparam int F_DEPTH = 16;
    localparam int F_TILED = 19;

    // log2 of bits per texel for a depth code
    function automatic lg_t depth_lb(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd0;
            3'd1:    return 5'd1;
            3'd2:    return 5'd2;
            3'd3:    return 5'd3;
            3'd7:    return 5'd5;
            default: return 5'd4;
        endcase
    endfunction

    // log2 tile width for a bpp log
    function automatic lg_t tile_wl(input lg_t lb);
        return 5'd4 - ((lb + 5'd1) >> 1);
    endfunction

    // log2 tile height for a bpp log
    function automatic lg_t tile_hl(input lg_t lb);
        return 5'd4 - (lb >> 1);
    endfunction

    // saturating subtract of two logs (dimension never below 1 texel)
    function automatic lg_t lg_sub(input lg_t a, input lg_t b);
        return (a > b) ? (a - b) : 5'd0;
    endfunction

    // log2 row pitch in bytes for linear layout (at least 8 bytes)
    function automatic lg_t pitch_lg(input lg_t wl, input lg_t lb);
        return ((wl + lb) > 5'd6) ? (wl + lb - 5'd3) : 5'd3;
    endfunction

    // log2 byte size of one level in either layout
    function automatic lg_t level_size_lg(input lg_t wl, input lg_t hl,
                                          input lg_t lb, input logic tiled);
        if (tiled)
            return lg_sub(wl, tile_wl(lb)) + lg_sub(hl, tile_hl(lb)) + 5'd5;
        else
            return pitch_lg(wl, lb) + hl;
    endfunction

endpackage

// File: rtl/tex_axis_fold.sv
// Applies one axis boundary rule (repeat, reflect, pin) to a signed
// coordinate and returns an index in [0, 2^size_lg). Assumes size_lg <= MAX_LOG.
module tex_axis_fold
    import tex_addr_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int IDX_W   = MAX_LOG
) (
    input  logic signed [COORD_W-1:0] coord,
    input  logic [1:0]                mode,
    input  lg_t                       size_lg,
    output logic [IDX_W-1:0]          idx
);

    logic [COORD_W-1:0] mask;
    logic [COORD_W-1:0] low;
    logic [COORD_W-1:0] res;
    logic               odd_rep;

    // mask of the valid low bits and the parity of the repetition
    always_comb begin
        mask    = (COORD_W'(1) << size_lg) - COORD_W'(1);
        low     = coord & mask;
        odd_rep = coord[size_lg[3:0]];
    end

    // select the folded value for the axis mode
    always_comb begin
        case (bnd_mode_t'(mode))
            BND_REFLECT: res = odd_rep ? (mask - low) : low;
            BND_PIN: begin
                if (coord[COORD_W-1])
                    res = '0;
                else if ($signed(coord) > $signed(mask))
                    res = mask;
                else
                    res = coord;
            end
            default:     res = low;
        endcase
        idx = res[IDX_W-1:0];
    end

endmodule

// File: rtl/tex_level_map.sv
// Picks the effective mipmap level, its log2 dimensions and the byte offset
// of its storage from the texture base. Assumes the layout is uniform across levels.
module tex_level_map
    import tex_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  lg_t               x_lg_full,
    input  lg_t               y_lg_full,
    input  lg_t               lvl_last,
    input  logic [3:0]        lod,
    input  lg_t               lb,
    input  logic              tiled,
    output lg_t               wl,
    output lg_t               hl,
    output logic [ADDR_W-1:0] lvl_off
);

    lg_t lvl_eff;

    // clamp the requested level to the last one present
    always_comb begin
        lvl_eff = ({1'b0, lod} > lvl_last) ? lvl_last : {1'b0, lod};
        wl      = lg_sub(x_lg_full, lvl_eff);
        hl      = lg_sub(y_lg_full, lvl_eff);
    end

    // sum the storage of every level below the selected one
    always_comb begin
        lvl_off = '0;
        for (int k = 0; k < MAX_LVLS; k++) begin
            if (lg_t'(k) < lvl_eff)
                lvl_off = lvl_off + (ADDR_W'(1) << level_size_lg(
                              lg_sub(x_lg_full, lg_t'(k)),
                              lg_sub(y_lg_full, lg_t'(k)), lb, tiled));
        end
    end

endmodule

// File: rtl/tex_layout.sv
// Converts a folded texel position into a byte offset of its 64-bit word
// within a level and a bit offset in that word, for linear or tiled storage.
// Assumes x < 2^wl and y < 2^hl.
module tex_layout
    import tex_addr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = MAX_LOG
) (
    input  logic [IDX_W-1:0]  x,
    input  logic [IDX_W-1:0]  y,
    input  lg_t               wl,
    input  lg_t               lb,
    input  logic              tiled,
    output logic [ADDR_W-1:0] off,
    output logic [5:0]        bitoff
);

    localparam int BITS_W = IDX_W + 6;

    logic [BITS_W-1:0] lin_bits;
    logic [ADDR_W-1:0] lin_off;
    lg_t               tw, th, tx_lg;
    logic [IDX_W-1:0]  tcol, trow, lx, ly, sub;
    logic [IDX_W+1:0]  tex_no;
    logic [BITS_W-1:0] tile_bits;
    logic [ADDR_W-1:0] tile_off;

    // linear: row pitch times y plus the word holding x
    always_comb begin
        lin_bits = BITS_W'(x) << lb;
        lin_off  = (ADDR_W'(y) << pitch_lg(wl, lb))
                 + (ADDR_W'(lin_bits >> 6) << 3);
    end

    // tiled: pick the tile, then the 2x2 group and texel inside it
    always_comb begin
        tw        = tile_wl(lb);
        th        = tile_hl(lb);
        tx_lg     = lg_sub(wl, tw);
        tcol      = x >> tw;
        trow      = y >> th;
        lx        = x & ((IDX_W'(1) << tw) - IDX_W'(1));
        ly        = y & ((IDX_W'(1) << th) - IDX_W'(1));
        sub       = ((ly >> 1) << (tw - 5'd1)) + (lx >> 1);
        tex_no    = {sub, ly[0], lx[0]};
        tile_bits = BITS_W'(tex_no) << lb;
        tile_off  = (((ADDR_W'(trow) << tx_lg) + ADDR_W'(tcol)) << 5)
                  + (ADDR_W'(tile_bits >> 6) << 3);
    end

    // choose the active layout
    always_comb begin
        off    = tiled ? tile_off : lin_off;
        bitoff = tiled ? tile_bits[5:0] : lin_bits[5:0];
    end

endmodule

// File: rtl/tex_addr_gen.sv
// Top of the texel address generator: decodes the control word, folds both
// axes, finds the level storage and the texel location, and registers the
// result behind a one-entry valid/ready output stage.
// Assumes the base address is 8-byte aligned (low bits are dropped).
module tex_addr_gen
    import tex_addr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int COORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_base,
    input  logic [CTRL_W-1:0]   in_ctrl,
    input  logic [COORD_W-1:0]  in_u,
    input  logic [COORD_W-1:0]  in_v,
    input  logic [3:0]          in_lod,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [5:0]          out_bitoff,
    output logic [2:0]          out_depth
);

    localparam int IDX_W = MAX_LOG;
    localparam int NAXES = 2;

    lg_t               x_lg_full, y_lg_full, lvl_last, lb;
    logic [2:0]        depth_code;
    logic              tiled;
    lg_t               wl, hl;
    logic [ADDR_W-1:0] lvl_off, lay_off, word_addr;
    logic [5:0]        bitoff;

    logic [COORD_W-1:0] ax_coord [NAXES];
    logic [1:0]         ax_mode  [NAXES];
    lg_t                ax_lg    [NAXES];
    logic [IDX_W-1:0]   ax_idx   [NAXES];

    // clamp a 4-bit size field to the supported maximum
    function automatic lg_t field_lg(input logic [3:0] f);
        return (f > 4'(MAX_LOG)) ? lg_t'(MAX_LOG) : {1'b0, f};
    endfunction

    // decode the control word fields
    always_comb begin
        x_lg_full  = field_lg(in_ctrl[F_XLOG +: 4]);
        y_lg_full  = field_lg(in_ctrl[F_YLOG +: 4]);
        lvl_last   = field_lg(in_ctrl[F_LVLS +: 4]);
        depth_code = in_ctrl[F_DEPTH +: 3];
        tiled      = in_ctrl[F_TILED];
        lb         = depth_lb(depth_code);
    end

    // per-axis inputs for the fold stage
    always_comb begin
        ax_coord[0] = in_u;
        ax_coord[1] = in_v;
        ax_mode[0]  = in_ctrl[F_UMODE +: 2];
        ax_mode[1]  = in_ctrl[F_VMODE +: 2];
        ax_lg[0]    = wl;
        ax_lg[1]    = hl;
    end

    tex_level_map #(.ADDR_W(ADDR_W)) u_lvl (
        .x_lg_full (x_lg_full),
        .y_lg_full (y_lg_full),
        .lvl_last  (lvl_last),
        .lod       (in_lod),
        .lb        (lb),
        .tiled     (tiled),
        .wl        (wl),
        .hl        (hl),
        .lvl_off   (lvl_off)
    );

    for (genvar a = 0; a < NAXES; a++) begin : g_axis
        tex_axis_fold #(.COORD_W(COORD_W), .IDX_W(IDX_W)) u_fold (
            .coord   (ax_coord[a]),
            .mode    (ax_mode[a]),
            .size_lg (ax_lg[a]),
            .idx     (ax_idx[a])
        );
    end

    tex_layout #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lay (
        .x      (ax_idx[0]),
        .y      (ax_idx[1]),
        .wl     (wl),
        .lb     (lb),
        .tiled  (tiled),
        .off    (lay_off),
        .bitoff (bitoff)
    );

    // final word address from aligned base, level start and texel offset
    always_comb begin
        word_addr = {in_base[ADDR_W-1:3], 3'b000} + lvl_off + lay_off;
        in_ready  = !out_valid || out_ready;
    end

    // one-entry output register with hold while the consumer stalls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            out_bitoff <= '0;
            out_depth  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr   <= word_addr;
                out_bitoff <= bitoff;
                out_depth  <= depth_code;
            end
        end
    end

endmodule

// File: rtl/tex_addr_gen_chk.sv
// Port-level properties of the texel address generator, bound to every instance.
module tex_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [5:0]        out_bitoff,
    input logic [2:0]        out_depth
);

    assert_reset_idle_R12: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_accept_shows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_empty_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
            && $stable(out_bitoff) && $stable(out_depth));

    assert_word_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr[2:0] == 3'b000);

    assert_texel_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_depth == 3'd7 |-> out_bitoff[4:0] == 5'd0);

    assert_half_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_depth[2] && out_depth != 3'd7 |-> out_bitoff[3:0] == 4'd0);

endmodule

bind tex_addr_gen tex_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_bitoff (out_bitoff),
    .out_depth  (out_depth)
);

// File: tb/sim_tex_addr_gen.sv
module sim_tex_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_base = '0;
    logic [19:0] in_ctrl = '0;
    logic [15:0] in_u = '0;
    logic [15:0] in_v = '0;
    logic [3:0]  in_lod = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic [5:0]  out_bitoff;
    logic [2:0]  out_depth;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] addr;
        logic [5:0]  bo;
        logic [2:0]  dep;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    tex_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_base(in_base), .in_ctrl(in_ctrl), .in_u(in_u), .in_v(in_v),
        .in_lod(in_lod), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_bitoff(out_bitoff), .out_depth(out_depth)
    );

    function automatic logic [19:0] mk(int um, int vm, int xl, int yl,
                                       int lv, int dep, int til);
        logic [19:0] c;
        c = '0;
        c[1:0] = 2'(um); c[3:2] = 2'(vm); c[7:4] = 4'(xl); c[11:8] = 4'(yl);
        c[15:12] = 4'(lv); c[18:16] = 3'(dep); c[19] = 1'(til);
        return c;
    endfunction

    function automatic int bpp_of(int d);
        case (d)
            0: return 1; 1: return 2; 2: return 4; 3: return 8;
            7: return 32; default: return 16;
        endcase
    endfunction

    function automatic int tile_w(int bpp);
        case (bpp)
            1: return 16; 2: return 8; 4: return 8; 8: return 4;
            16: return 4; default: return 2;
        endcase
    endfunction

    function automatic int tile_h(int bpp);
        case (bpp)
            1: return 16; 2: return 16; 4: return 8; 8: return 8;
            default: return 4;
        endcase
    endfunction

    function automatic int fold(int c, int mode, int sz);
        int p, m;
        p = (c >= 0) ? c / sz : -(((-c) + sz - 1) / sz);
        m = c - p * sz;
        if (mode == 1) return (p % 2 != 0) ? sz - 1 - m : m;
        if (mode == 2) return (c < 0) ? 0 : ((c >= sz) ? sz - 1 : c);
        return m;
    endfunction

    function automatic int dim(int full, int k);
        return (full > k) ? (1 << (full - k)) : 1;
    endfunction

    function automatic longint lvl_bytes(int w, int h, int bpp, int til);
        if (til == 0) return longint'((w * bpp + 63) / 64 * 8) * h;
        return longint'((w + tile_w(bpp) - 1) / tile_w(bpp))
             * ((h + tile_h(bpp) - 1) / tile_h(bpp)) * 32;
    endfunction

    function automatic exp_t ref_model(logic [31:0] base, logic [19:0] c,
                                       int u, int v, int lod, string tag);
        exp_t e;
        int xl, yl, lv, bpp, til, n, w, h, x, y, tw, th, t, bits, tcols;
        longint acc;
        xl = (c[7:4] > 8) ? 8 : int'(c[7:4]);
        yl = (c[11:8] > 8) ? 8 : int'(c[11:8]);
        lv = (c[15:12] > 8) ? 8 : int'(c[15:12]);
        bpp = bpp_of(int'(c[18:16]));
        til = int'(c[19]);
        n = (lod > lv) ? lv : lod;
        acc = longint'({base[31:3], 3'b000});
        for (int k = 0; k < n; k++) acc += lvl_bytes(dim(xl, k), dim(yl, k), bpp, til);
        w = dim(xl, n); h = dim(yl, n);
        x = fold(u, int'(c[1:0]), w);
        y = fold(v, int'(c[3:2]), h);
        if (til == 0) begin
            acc += longint'(y) * ((w * bpp + 63) / 64 * 8) + (x * bpp / 64) * 8;
            bits = x * bpp;
        end else begin
            tw = tile_w(bpp); th = tile_h(bpp);
            tcols = (w + tw - 1) / tw;
            t = ((y % th) / 2) * (tw / 2) + (x % tw) / 2;
            t = t * 4 + (y % 2) * 2 + (x % 2);
            bits = t * bpp;
            acc += longint'((y / th) * tcols + x / tw) * 32 + (bits / 64) * 8;
        end
        e.addr = acc[31:0];
        e.bo = 6'(bits % 64);
        e.dep = c[18:16];
        e.tag = tag;
        return e;
    endfunction

    task automatic send(logic [31:0] base, logic [19:0] c, int u, int v,
                        int lod, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_base = base; in_ctrl = c;
        in_u = 16'(u); in_v = 16'(v); in_lod = 4'(lod);
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        sb.push_back(ref_model(base, c, u, v, lod, tag));
        @(posedge clk);
    endtask

    // monitor: sets consumer readiness, checks hold and pops the scoreboard
    logic        was_stall = 0;
    logic [31:0] h_addr;
    logic [5:0]  h_bo;
    logic [2:0]  h_dep;
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (rst_n) begin
            if (was_stall) begin
                n_checks++;
                if (!out_valid || out_addr != h_addr || out_bitoff != h_bo || out_depth != h_dep) begin
                    n_fail++;
                    $display("FAIL R2 hold: got v=%0b %h/%0d/%0d exp %h/%0d/%0d",
                             out_valid, out_addr, out_bitoff, out_depth, h_addr, h_bo, h_dep);
                end
            end
            out_ready = (cyc % 7 != 3) && (cyc % 11 != 5);
            was_stall = out_valid && !out_ready;
            h_addr = out_addr; h_bo = out_bitoff; h_dep = out_depth;
            if (out_valid && out_ready) begin
                n_checks++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R1 unexpected result %h, exp none", out_addr);
                end else begin
                    e = sb.pop_front();
                    if (out_addr != e.addr || out_bitoff != e.bo || out_depth != e.dep) begin
                        n_fail++;
                        $display("FAIL %s: got %h/%0d/%0d exp %h/%0d/%0d", e.tag,
                                 out_addr, out_bitoff, out_depth, e.addr, e.bo, e.dep);
                    end
                end
            end
        end
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: got hang exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        n_checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R12: got valid=%0b ready=%0b exp 0/1", out_valid, in_ready);
        end
        rst_n = 1'b1;

        // R3 wrap, R13 reserved code acts as wrap
        send(32'h1000, mk(0, 0, 3, 3, 0, 3, 0), -1, 9, 0, "R3");
        send(32'h1000, mk(3, 3, 3, 3, 0, 3, 0), -9, 17, 0, "R3");
        // R4 mirror
        send(32'h2000, mk(1, 1, 3, 3, 0, 3, 0), 9, -1, 0, "R4");
        send(32'h2000, mk(1, 1, 3, 3, 0, 3, 0), -12, 23, 0, "R4");
        // R5 clamp
        send(32'h3000, mk(2, 2, 3, 3, 0, 3, 0), -5, 100, 0, "R5");
        send(32'h3000, mk(2, 2, 3, 3, 0, 3, 0), 6, 8, 0, "R5");
        // R6/R7 level selection and clamp
        send(32'h4000, mk(0, 0, 4, 3, 2, 4, 0), 3, 1, 1, "R7");
        send(32'h4000, mk(0, 0, 4, 3, 2, 4, 0), 3, 1, 9, "R6");
        send(32'h4000, mk(0, 0, 4, 3, 8, 7, 1), 1, 1, 8, "R6");
        // R8 linear sub-byte packing and narrow pitch
        send(32'h5007, mk(0, 0, 6, 2, 0, 0, 0), 45, 2, 0, "R8");
        send(32'h5000, mk(0, 0, 2, 2, 0, 1, 0), 3, 3, 0, "R8");
        // R9 every depth code
        for (int d = 0; d < 8; d++)
            send(32'h6000, mk(0, 0, 5, 5, 0, d, 0), 19, 7, 0, "R9");
        // R10 tiled for every depth, R11 positions inside a 2x2 group
        for (int d = 0; d < 8; d++)
            send(32'h7000, mk(0, 0, 6, 5, 1, d, 1), 37, 21, 0, "R10");
        for (int i = 0; i < 4; i++)
            send(32'h8000, mk(0, 0, 3, 3, 0, 3, 1), 2 + i % 2, 4 + i / 2, 0, "R11");
        // R13 oversize fields act as 8
        send(32'h9000, mk(0, 0, 12, 15, 15, 6, 0), 300, 513, 11, "R13");
        // back-to-back burst under consumer stalls (R1, R2)
        for (int i = 0; i < 6; i++)
            send(32'hA000, mk(0, 0, 4, 4, 0, 5, 0), i, i, 0, "R1");

        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            send({lf[19:3], 3'b000} ^ 32'h10000,
                 mk(int'(lf[1:0]), int'(lf[3:2]), int'(lf[7:4]) % 10, int'(lf[11:8]) % 10,
                    int'(lf[15:12]) % 10, int'(lf[18:16]), int'(lf[19])),
                 int'(lf[30:20]) - 1024, int'(lf[29:19]) - 700, int'(lf[25:22]),
                 lf[19] ? "R10" : "R8");
        end

        @(negedge clk);
        in_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule